// File: doc/BRIEF.md
# Multiphase Sub-Clock Edge Interpolator

This block measures where a rising edge of an asynchronous measurement signal lands inside one period of a fast clock, to a resolution of one eighth of that period. A set of phase clocks is supplied alongside the main clock. Phase clock k rises k/8 of a period after phase 0 rises, and each phase clock is high for half a period. On every rising measurement edge, the levels of the four phase clocks are frozen. Four half-duty phases spaced by an eighth of a period give eight distinct patterns, forming a rotating thermometer code, so four phases are enough to tell the eight locations apart.

The frozen pattern is carried into the main clock domain through a synchronizer and decoded to a 3-bit location. The location is then differenced against the location of the previous good edge, modulo 8. A period counter elsewhere supplies the whole-period part of the interval between measurement edges. The fractional difference from this block refines that interval below one clock period. A pattern that no edge position could produce is reported as an error and does not disturb the tracked location.

Top module: `subclk_edge_interp`

## Requirements
- R1: While and after synchronous reset (rst high at a clk rising edge), loc_o, frac_o, valid_o and err_o are all 0 until a measurement edge is processed.
- R2: The phase pattern bit k is the level of phase_i[k] at the meas_i rising edge. The reported location L satisfies bit k = 1 exactly when ((L - k) mod 8) < 4. So 0001→0, 0011→1, 0111→2, 1111→3, 1110→4, 1100→5, 1000→6 and 0000→7, written as bit 3 down to bit 0. An edge falling in eighth L of the period, counted from the phase 0 rise, reports L.
- R3: The first edge with a valid pattern after reset updates loc_o but keeps valid_o low.
- R4: Every later valid-pattern edge raises valid_o for exactly one cycle, updates loc_o, and sets frac_o to (new location − previous good location) mod 8.
- R5: An edge whose pattern is not one of the eight codes of R2 raises err_o for one cycle. In that case valid_o stays low, loc_o and frac_o are unchanged, and the next good edge is differenced against the last good location.
- R6: With SYNC_STAGES = 2, the results of an edge appear on the fourth clk rising edge after the meas_i rise. valid_o and err_o stay low on all other cycles.
- R7: An edge that coincides with the phase 0 rise reports location 7 or 0, and either one is differenced consistently.
- R8: Falling edges of meas_i, and meas_i held high, produce no valid_o or err_o pulse.
- R9: The difference wraps in 3 bits, so a new location below the previous one gives 8 minus the backward distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main fast clock, in phase with phase_i[0] |
| rst | input | 1 | Synchronous active-high reset |
| meas_i | input | 1 | Asynchronous measurement signal, rising edge is timed |
| phase_i | input | NUM_PH (4) | Phase clocks, bit k delayed by k/8 period |
| loc_o | output | 3 | Location of the last good edge |
| frac_o | output | 3 | Fractional difference between the last two good edges |
| valid_o | output | 1 | One-cycle strobe for a new frac_o |
| err_o | output | 1 | One-cycle strobe for an invalid phase pattern |

## Verification
The bench places edges in each of the eight eighths of the period and checks the decoded location. If the decode table were rotated or mirrored, these locations would come out wrong. Pairs of edges that step backwards exercise the modulo-8 difference. A signed or widened subtractor would give the wrong fraction there. Forced illegal patterns, both before and after the first good edge, check two things: that the tracked location survives, and that the first edge only primes the difference. A design that updated on bad codes, or strobed on the first edge, would show a wrong fraction or a stray valid. The bench also checks the exact output latency, an edge placed exactly on the phase 0 rise, and the absence of pulses on falling edges. A detector that fired on both edges or re-fired while the signal stayed high would fail those checks.

// File: rtl/sci_pkg.sv
`timescale 1ns/1ps
package sci_pkg;
    localparam int unsigned NUM_PH  = 4;
    localparam int unsigned NUM_LOC = 2 * NUM_PH;
    localparam int unsigned LOC_W   = $clog2(NUM_LOC);

    typedef logic [LOC_W-1:0]  loc_t;
    typedef logic [NUM_PH-1:0] pat_t;

    typedef struct packed {
        logic ok;
        loc_t loc;
    } dec_t;

    // Level pattern of the phase clocks when the edge falls in eighth 'loc'.
    function automatic pat_t ring_pattern(input int unsigned loc);
        pat_t p;
        for (int unsigned k = 0; k < NUM_PH; k++) begin
            p[k] = (((loc + NUM_LOC - k) % NUM_LOC) < NUM_PH);
        end
        return p;
    endfunction

    // Match a sampled pattern against every legal rotated thermometer code.
    function automatic dec_t decode_ring(input pat_t p);
        dec_t d;
        d.ok  = 1'b0;
        d.loc = '0;
        for (int unsigned l = 0; l < NUM_LOC; l++) begin
            if (p == ring_pattern(l)) begin
                d.ok  = 1'b1;
                d.loc = loc_t'(l);
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/sci_capture.sv
`timescale 1ns/1ps
module sci_capture
    import sci_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic meas,
    input  pat_t phase,
    output pat_t pat_o,
    output logic evt_o
);
    localparam int unsigned MCHAIN = SYNC_STAGES + 2;

    pat_t              cap_q;
    pat_t              dsync [SYNC_STAGES];
    logic [MCHAIN-1:0] msync;

    // Freeze phase levels at the measurement rising edge.
    always_ff @(posedge meas) begin
        cap_q <= phase;
    end

    // Measurement chain runs one stage longer than the data chain so the
    // data has settled a full cycle before the event is seen.
    always_ff @(posedge clk) begin
        if (rst) begin
            msync <= '0;
        end else begin
            msync <= {msync[MCHAIN-2:0], meas};
        end
    end

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_dsync
        always_ff @(posedge clk) begin
            if (rst) begin
                dsync[i] <= '0;
            end else if (i == 0) begin
                dsync[i] <= cap_q;
            end else begin
                dsync[i] <= dsync[(i == 0) ? 0 : i-1];
            end
        end
    end

    assign evt_o = msync[SYNC_STAGES] & ~msync[SYNC_STAGES+1];
    assign pat_o = dsync[SYNC_STAGES-1];

    // R8: only rising edges produce events, never two cycles in a row
    p_evt_single_r8: assert property (@(posedge clk) disable iff (rst)
        evt_o |=> !evt_o);
endmodule

// File: rtl/sci_decode.sv
`timescale 1ns/1ps
module sci_decode
    import sci_pkg::*;
(
    input  pat_t pat_i,
    output dec_t dec_o
);
    dec_t dec;

    always_comb begin
        dec = decode_ring(pat_i);
    end

    assign dec_o = dec;

    // R2: phase 0 is high exactly in the first half of the period
    always_comb begin
        if (dec.ok) begin
            p_bit0_r2: assert (pat_i[0] == (dec.loc < NUM_PH));
        end
    end
endmodule

// File: rtl/sci_track.sv
`timescale 1ns/1ps
module sci_track
    import sci_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  dec_t dec_i,
    output loc_t loc_o,
    output loc_t frac_o,
    output logic valid_o,
    output logic err_o
);
    logic primed_q;
    loc_t loc_q;
    loc_t frac_q;
    logic valid_q;
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q <= 1'b0;
            loc_q    <= '0;
            frac_q   <= '0;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            if (evt_i) begin
                if (dec_i.ok) begin
                    loc_q    <= dec_i.loc;
                    primed_q <= 1'b1;
                    if (primed_q) begin
                        valid_q <= 1'b1;
                        frac_q  <= dec_i.loc - loc_q;
                    end
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    assign loc_o   = loc_q;
    assign frac_o  = frac_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;

    // R3: a strobe needs an earlier good edge
    p_first_silent_r3: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(primed_q));

    // R4: the fraction is the forward step of the location
    p_frac_step_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (frac_o == loc_t'(loc_o - $past(loc_o))));

    // R4: strobe lasts one cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R5: an error leaves the results untouched
    p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($stable(loc_o) && $stable(frac_o) && !valid_o));
endmodule

// File: rtl/subclk_edge_interp.sv
`timescale 1ns/1ps
module subclk_edge_interp
    import sci_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              meas_i,
    input  logic [NUM_PH-1:0] phase_i,
    output logic [LOC_W-1:0]  loc_o,
    output logic [LOC_W-1:0]  frac_o,
    output logic              valid_o,
    output logic              err_o
);
    pat_t pat;
    logic evt;
    dec_t dec;

    sci_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk   (clk),
        .rst   (rst),
        .meas  (meas_i),
        .phase (phase_i),
        .pat_o (pat),
        .evt_o (evt)
    );

    sci_decode u_decode (
        .pat_i (pat),
        .dec_o (dec)
    );

    sci_track u_track (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .dec_i   (dec),
        .loc_o   (loc_o),
        .frac_o  (frac_o),
        .valid_o (valid_o),
        .err_o   (err_o)
    );

    // R5: a result and an error never coincide
    p_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && err_o));
endmodule

// File: tb/tb_subclk_edge_interp.sv
`timescale 1ns/1ps
module tb_subclk_edge_interp;
    logic       clk;
    logic       rst;
    logic       meas;
    logic [3:0] ph_gen;
    logic [3:0] ph_in;
    logic       force_bad;
    logic [3:0] bad_val;
    logic [2:0] loc_o;
    logic [2:0] frac_o;
    logic       valid_o;
    logic       err_o;

    int  total = 0;
    int  fails = 0;
    bit  done  = 0;

    // model state
    bit       primed   = 0;
    int       last_loc = 0;
    int       last_frac = 0;

    assign ph_in = force_bad ? bad_val : ph_gen;

    subclk_edge_interp dut (
        .clk     (clk),
        .rst     (rst),
        .meas_i  (meas),
        .phase_i (ph_in),
        .loc_o   (loc_o),
        .frac_o  (frac_o),
        .valid_o (valid_o),
        .err_o   (err_o)
    );

    function automatic logic [3:0] bench_pat(input int l);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) p[k] = (((l - k + 8) % 8) < 4);
        return p;
    endfunction

    function automatic bit legal(input logic [3:0] p);
        bit r = 0;
        for (int l = 0; l < 8; l++) if (bench_pat(l) == p) r = 1;
        return r;
    endfunction

    // 100 MHz clock with eight 1.25 ns steps; clk equals phase 0
    initial begin
        ph_gen = 4'b0000;
        clk    = 1'b0;
        forever begin
            for (int s = 0; s < 8; s++) begin
                for (int k = 0; k < 4; k++) ph_gen[k] = (((s - k + 8) % 8) < 4);
                clk = ph_gen[0];
                #1.25;
            end
        end
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fall_and_quiet();
        bit pulse = 0;
        repeat (2) @(posedge clk);
        #($urandom_range(1, 9));
        meas = 1'b0;
        for (int c = 0; c < 6; c++) begin
            @(posedge clk); #2;
            if (valid_o || err_o) pulse = 1;
        end
        chk(!pulse, "R8 no pulse on fall/high", int'(pulse), 0);
    endtask

    task automatic run_edge(input int l, input bit bad, input logic [3:0] bpat);
        bit exp_valid = !bad && primed;
        int exp_loc   = bad ? last_loc : l;
        int exp_frac  = exp_valid ? ((l - last_loc + 8) % 8) : last_frac;
        string freq   = (exp_valid && l < last_loc) ? "R9 wrap frac" : "R4 frac";
        @(posedge clk);
        #(real'(l) * 1.25 + 0.5);
        if (bad) begin
            bad_val   = bpat;
            force_bad = 1'b1;
        end
        #0.1;
        meas = 1'b1;
        #0.1;
        force_bad = 1'b0;
        for (int c = 1; c <= 6; c++) begin
            @(posedge clk); #2;
            if (c == 4) begin
                chk(valid_o == exp_valid, primed ? "R4 valid" : "R3 first edge silent",
                    int'(valid_o), int'(exp_valid));
                chk(err_o == bad, "R5 err flag", int'(err_o), int'(bad));
                chk(int'(loc_o) == exp_loc, bad ? "R5 loc hold" : "R2 location",
                    int'(loc_o), exp_loc);
                chk(int'(frac_o) == exp_frac, bad ? "R5 frac hold" : freq,
                    int'(frac_o), exp_frac);
            end else begin
                chk(!valid_o && !err_o, "R6 latency", int'({valid_o, err_o}), 0);
            end
        end
        if (!bad) begin
            if (primed) last_frac = exp_frac;
            primed   = 1;
            last_loc = l;
        end
        fall_and_quiet();
    endtask

    task automatic run_boundary();
        bit seen = 0;
        int got  = 0;
        @(posedge clk);
        meas = 1'b1;
        for (int c = 0; c < 7; c++) begin
            @(posedge clk); #2;
            if (valid_o && !seen) begin
                seen = 1;
                got  = int'(loc_o);
                chk(got == 0 || got == 7, "R7 boundary location", got, 0);
                chk(int'(frac_o) == ((got - last_loc + 8) % 8), "R7 boundary frac",
                    int'(frac_o), (got - last_loc + 8) % 8);
            end
        end
        chk(seen, "R7 boundary strobe", int'(seen), 1);
        if (seen) begin
            last_frac = (got - last_loc + 8) % 8;
            last_loc  = got;
        end
        fall_and_quiet();
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [3:0] bp;
        void'($urandom(32'd2024));
        rst = 1'b1;
        meas = 1'b0;
        force_bad = 1'b0;
        bad_val = 4'b0000;
        repeat (5) @(posedge clk);
        #2;
        chk(loc_o == 0 && frac_o == 0 && !valid_o && !err_o, "R1 reset state",
            int'({loc_o, frac_o, valid_o, err_o}), 0);
        @(posedge clk);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(loc_o == 0 && frac_o == 0 && !valid_o && !err_o, "R1 after reset",
            int'({loc_o, frac_o, valid_o, err_o}), 0);

        run_edge(0, 1, 4'b0101);   // bad before priming
        run_edge(3, 0, 4'b0000);   // first good edge
        run_edge(5, 0, 4'b0000);
        run_edge(5, 0, 4'b0000);   // zero step
        run_edge(1, 0, 4'b0000);   // wrap
        run_edge(6, 0, 4'b0000);
        run_edge(0, 0, 4'b0000);   // wrap
        run_edge(4, 1, 4'b1010);   // bad after priming
        run_edge(2, 0, 4'b0000);   // differenced against last good
        for (int l = 0; l < 8; l++) run_edge(l, 0, 4'b0000);
        run_edge(7, 0, 4'b0000);
        run_boundary();
        run_edge(3, 0, 4'b0000);

        for (int i = 0; i < 40; i++) begin
            bit b = ($urandom_range(0, 7) == 0);
            bp = 4'b0000;
            if (b) begin
                bp = 4'($urandom_range(0, 15));
                while (legal(bp)) bp = 4'($urandom_range(0, 15));
            end
            run_edge($urandom_range(0, 7), b, bp);
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule